// File: doc/BRIEF.md
# Column Command Decoder with One-Entry Write Buffer

This block sits behind the column-control pins of a memory device. It frames column packets and decodes the command carried in each one. Each packet arrives as four beats of ten bits, one beat per clock. The decoded read, write, precharge, calibration and standby requests are issued as one-cycle strobes. Write data is not sent to storage when it arrives. A write is parked in a single-entry buffer, together with its bank, column and sixteen data bytes. It is retired later, when a qualifying column packet arrives.

The low part of each packet either carries a pair of byte masks or an extended command with its own device and bank fields. A mask pair belongs to the write waiting in the buffer, but only if that write was decoded long enough before the mask. A write that reaches retirement without an accepted mask has every byte enabled. A write with auto-precharge asks for its bank to be precharged only when its own data is retired.

Top module: `colcmd_unit`

## Requirements
- R1: A packet starts on a beat whose bit 9 is 1 while no packet is in progress, and it lasts four beats. The first beat supplies packet bits 39:30 and each later beat the next ten bits down. Bit 39 is the start bit, 38:34 the device, 33:29 the bank, 28:23 the column and 22:19 the opcode. Bits 18:17 are ignored. Bit 16 selects the low part: 1 means a mask pair with lane-A mask in 15:8 and lane-B mask in 7:0, and 0 means an extended command with device in 15:11, bank in 10:6 and opcode in 5:1. The results for a packet appear during the one cycle that follows the fifth rising edge, counting the edge that samples the start beat as the first.
- R2: A start beat is recognised only while `attn_i` is 1. A packet sent while it is 0 issues no strobe and leaves the buffer untouched.
- R3: For a matching device, opcode low bits 011 or 111 issue a read with the packet's bank and column. A read never retires the buffer.
- R4: For a matching device, opcode low bits 001 or 101 issue a write strobe and load the bank, column and `wdata_i` into the buffer. The previous buffered entry is retired in the same packet.
- R5: The buffered entry is retired by a matching packet whose opcode low bits are 000, 001, 100 or 101, and by any packet addressed to another device. Low bits 011, 111, 010 and 110 on a matching packet do not retire it, and nothing is retired while the buffer is empty.
- R6: A retirement presents the buffered bank, column and data. Byte enable bit k covers data byte k: bits 7:0 come from the lane-A mask and 15:8 from the lane-B mask. The enables are all ones when no mask was accepted.
- R7: A mask pair is accepted for the buffered write only if its packet is decoded at least `RTR_CYC` (8) cycles after the write's packet. A mask that arrives earlier is ignored. An accepted mask is kept until retirement, even if it arrives on a packet that does not retire.
- R8: For a matching device, opcode low bits 100 or 111 issue a precharge strobe for the packet's bank.
- R9: A write with auto-precharge (low bits 101) raises the buffer-precharge strobe with its own bank in the same cycle as the retirement of its data, and never earlier.
- R10: An extended command acts only when its device field matches `dev_id_i`, and bit 0 of its opcode must be 0. Bit 4 requests a precharge of the extended bank. Bit 3 requests calibration, and bits 3 and 2 together also request sampling. Any combination of these may be given in one packet.
- R11: A standby strobe is raised by opcode bit 3 on a matching packet, or by extended opcode bit 1 with bit 0 clear.
- R12: After reset every strobe output is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| attn_i | input | 1 | Device is in the attention power state |
| dev_id_i | input | 5 | This device's address |
| col_i | input | 10 | One packet beat per clock |
| wdata_i | input | 128 | Write data, sampled when a write packet is decoded |
| rd_v_o | output | 1 | Read strobe |
| rd_bank_o | output | 5 | Read bank |
| rd_col_o | output | 6 | Read column |
| wr_v_o | output | 1 | Write accepted into buffer |
| wr_bank_o | output | 5 | Bank of accepted write |
| wr_col_o | output | 6 | Column of accepted write |
| pre_v_o | output | 1 | Column-command precharge strobe |
| pre_bank_o | output | 5 | Bank for that precharge |
| xpre_v_o | output | 1 | Extended-command precharge strobe |
| xpre_bank_o | output | 5 | Bank for extended precharge |
| cal_v_o | output | 1 | Calibrate request |
| sam_v_o | output | 1 | Sample request |
| stby_v_o | output | 1 | Move to standby request |
| ret_v_o | output | 1 | Buffer retirement strobe |
| ret_bank_o | output | 5 | Retired bank |
| ret_col_o | output | 6 | Retired column |
| ret_data_o | output | 128 | Retired data bytes |
| ret_be_o | output | 16 | Retired byte enables |
| wbpre_v_o | output | 1 | Precharge after auto-precharge write retirement |
| wbpre_bank_o | output | 5 | Bank for that precharge |

## Verification
The start beat is sampled on one edge, and every result for that packet appears after the fifth edge, counting that one as the first. The bench drives four beats, idles one cycle, then samples on the following falling edge, so each check reads exactly the cycle its result is due. Because every packet spans six cycles in the bench, a mask carried on the next packet after a write is six cycles late and must be ignored, while one carried on the packet after that is twelve cycles late and must be accepted. The expected strobes come from arithmetic on swept opcode values: all sixteen column opcodes, each following a freshly buffered write, and all thirty-two extended opcodes.

// File: rtl/colpkt_pkg.sv
// Shared packet layout and decoded-command type for the column command unit.
package colpkt_pkg;
    localparam int BEATS    = 4;
    localparam int BEAT_W   = 10;
    localparam int PKT_W    = BEATS * BEAT_W;
    localparam int DEV_W    = 5;
    localparam int BANK_W   = 5;
    localparam int COL_W    = 6;
    localparam int OP_W     = 4;
    localparam int XOP_W    = 5;
    localparam int MSK_W    = 8;
    // Field positions inside the 40-bit packet word
    localparam int S_POS    = PKT_W - 1;
    localparam int DEV_LO   = S_POS - DEV_W;
    localparam int BANK_LO  = DEV_LO - BANK_W;
    localparam int COL_LO   = BANK_LO - COL_W;
    localparam int OP_LO    = COL_LO - OP_W;
    localparam int M_POS    = 16;
    localparam int MA_LO    = MSK_W;
    localparam int MB_LO    = 0;
    localparam int XDEV_LO  = M_POS - DEV_W;
    localparam int XBANK_LO = XDEV_LO - BANK_W;
    localparam int XOP_LO   = XBANK_LO - XOP_W;

    typedef struct packed {
        logic               retire;
        logic               rd;
        logic               wr;
        logic               wr_auto;
        logic               pre;
        logic               stby;
        logic               msk_v;
        logic [MSK_W-1:0]   ma;
        logic [MSK_W-1:0]   mb;
        logic               xpre;
        logic               cal;
        logic               sam;
        logic [BANK_W-1:0]  bank;
        logic [COL_W-1:0]   col;
        logic [BANK_W-1:0]  xbank;
    } dec_t;
endpackage

// File: rtl/colpkt_framer.sv
// Packet framer: recognises a start beat while idle and collects BEATS beats
// into one packet word. Assumes the start bit is the top bit of the first beat
// and that beats arrive one per clock with no gaps.
module colpkt_framer #(
    parameter int BEATS  = colpkt_pkg::BEATS,
    parameter int BEAT_W = colpkt_pkg::BEAT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      attn_i,
    input  logic [BEAT_W-1:0]         beat_i,
    output logic [BEATS*BEAT_W-1:0]   pkt_o,
    output logic                      pkt_vld_o
);
    localparam int PW    = BEATS * BEAT_W;
    localparam int CNT_W = $clog2(BEATS);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             start;

    assign start = !busy && attn_i && beat_i[BEAT_W-1];

    // Shift beats in and mark the packet complete after the last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            pkt_o     <= '0;
            pkt_vld_o <= 1'b0;
        end else begin
            pkt_vld_o <= 1'b0;
            if (start || busy)
                pkt_o <= {pkt_o[PW-BEAT_W-1:0], beat_i};
            if (start) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(1);
            end else if (busy) begin
                if (cnt == CNT_W'(BEATS - 1)) begin
                    busy      <= 1'b0;
                    cnt       <= '0;
                    pkt_vld_o <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R1
    pkt_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld_o |=> !pkt_vld_o);
endmodule

// File: rtl/colpkt_decode.sv
// Combinational decoder: turns a framed packet into command flags for this
// device. Assumes the packet word is already complete; validity is applied
// by the consumer.
module colpkt_decode
    import colpkt_pkg::*;
(
    input  logic [PKT_W-1:0] pkt_i,
    input  logic [DEV_W-1:0] dev_id_i,
    output dec_t             dec_o
);
    logic              s_bit, hit, m_bit, xhit;
    logic [OP_W-1:0]   op;
    logic [2:0]        low;
    logic [XOP_W-1:0]  xop;

    // Split fields and form the command flags
    always_comb begin
        s_bit = pkt_i[S_POS];
        hit   = (pkt_i[DEV_LO +: DEV_W] == dev_id_i);
        op    = pkt_i[OP_LO +: OP_W];
        low   = op[2:0];
        m_bit = pkt_i[M_POS];
        xop   = pkt_i[XOP_LO +: XOP_W];
        xhit  = !m_bit && (pkt_i[XDEV_LO +: DEV_W] == dev_id_i) && !xop[0];

        dec_o         = '0;
        dec_o.bank    = pkt_i[BANK_LO +: BANK_W];
        dec_o.col     = pkt_i[COL_LO +: COL_W];
        dec_o.xbank   = pkt_i[XBANK_LO +: BANK_W];
        dec_o.ma      = pkt_i[MA_LO +: MSK_W];
        dec_o.mb      = pkt_i[MB_LO +: MSK_W];
        dec_o.msk_v   = s_bit && m_bit;
        dec_o.retire  = s_bit && (!hit || low == 3'b000 || low == 3'b001 ||
                                  low == 3'b100 || low == 3'b101);
        dec_o.rd      = s_bit && hit && (low == 3'b011 || low == 3'b111);
        dec_o.wr      = s_bit && hit && (low == 3'b001 || low == 3'b101);
        dec_o.wr_auto = s_bit && hit && (low == 3'b101);
        dec_o.pre     = s_bit && hit && (low == 3'b100 || low == 3'b111);
        dec_o.xpre    = s_bit && xhit && xop[4];
        dec_o.cal     = s_bit && xhit && xop[3];
        dec_o.sam     = s_bit && xhit && xop[3] && xop[2];
        dec_o.stby    = s_bit && ((hit && op[3]) || (xhit && xop[1]));
    end
endmodule

// File: rtl/colpkt_wbuf.sv
// One-entry write buffer: holds a write until a retiring packet, attaches a
// late byte mask when old enough, and requests the deferred precharge of an
// auto-precharge write at its retirement. Assumes dec_i is valid only when
// pkt_vld_i is high.
module colpkt_wbuf
    import colpkt_pkg::*;
#(
    parameter int RTR_CYC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pkt_vld_i,
    input  dec_t                     dec_i,
    input  logic [2*MSK_W*8-1:0]     wdata_i,
    output logic                     ret_v_o,
    output logic [BANK_W-1:0]        ret_bank_o,
    output logic [COL_W-1:0]         ret_col_o,
    output logic [2*MSK_W*8-1:0]     ret_data_o,
    output logic [2*MSK_W-1:0]       ret_be_o,
    output logic                     pcw_v_o,
    output logic [BANK_W-1:0]        pcw_bank_o
);
    localparam int BE_W  = 2 * MSK_W;
    localparam int DW    = BE_W * 8;
    localparam int AGE_W = $clog2(RTR_CYC + 1);

    logic              bv, bauto, bmask_v;
    logic [BANK_W-1:0] bbank;
    logic [COL_W-1:0]  bcol;
    logic [DW-1:0]     bdata;
    logic [BE_W-1:0]   bmask, eff_be;
    logic [AGE_W-1:0]  age;
    logic              age_ok, new_mask_ok, do_ret;

    // Decide retirement and the byte enables that go with it
    always_comb begin
        age_ok      = (age >= AGE_W'(RTR_CYC));
        new_mask_ok = pkt_vld_i && dec_i.msk_v && bv && age_ok;
        do_ret      = pkt_vld_i && dec_i.retire && bv;
        if (new_mask_ok)
            eff_be = {dec_i.mb, dec_i.ma};
        else if (bmask_v)
            eff_be = bmask;
        else
            eff_be = '1;
    end

    // Register retirement outputs and the deferred precharge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_v_o    <= 1'b0;
            ret_bank_o <= '0;
            ret_col_o  <= '0;
            ret_data_o <= '0;
            ret_be_o   <= '0;
            pcw_v_o    <= 1'b0;
            pcw_bank_o <= '0;
        end else begin
            ret_v_o <= do_ret;
            pcw_v_o <= do_ret && bauto;
            if (do_ret) begin
                ret_bank_o <= bbank;
                ret_col_o  <= bcol;
                ret_data_o <= bdata;
                ret_be_o   <= eff_be;
                pcw_bank_o <= bbank;
            end
        end
    end

    // Maintain buffer contents, stored mask and write age
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bv      <= 1'b0;
            bauto   <= 1'b0;
            bmask_v <= 1'b0;
            bbank   <= '0;
            bcol    <= '0;
            bdata   <= '0;
            bmask   <= '0;
            age     <= '0;
        end else if (pkt_vld_i && dec_i.wr) begin
            bv      <= 1'b1;
            bauto   <= dec_i.wr_auto;
            bmask_v <= 1'b0;
            bbank   <= dec_i.bank;
            bcol    <= dec_i.col;
            bdata   <= wdata_i;
            age     <= AGE_W'(1);
        end else begin
            if (do_ret) begin
                bv      <= 1'b0;
                bmask_v <= 1'b0;
            end else if (new_mask_ok) begin
                bmask_v <= 1'b1;
                bmask   <= {dec_i.mb, dec_i.ma};
            end
            if (!age_ok)
                age <= age + AGE_W'(1);
        end
    end

    // R5
    ret_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_v_o |-> $past(bv));
    // R9
    autopre_with_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcw_v_o |-> ret_v_o);
endmodule

// File: rtl/colcmd_unit.sv
// Column command unit top: frames column packets, decodes them for this
// device, issues one-cycle command strobes and runs the write buffer.
// Assumes write data is presented on wdata_i while a write packet is decoded.
module colcmd_unit
    import colpkt_pkg::*;
#(
    parameter int RTR_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          attn_i,
    input  logic [4:0]    dev_id_i,
    input  logic [9:0]    col_i,
    input  logic [127:0]  wdata_i,
    output logic          rd_v_o,
    output logic [4:0]    rd_bank_o,
    output logic [5:0]    rd_col_o,
    output logic          wr_v_o,
    output logic [4:0]    wr_bank_o,
    output logic [5:0]    wr_col_o,
    output logic          pre_v_o,
    output logic [4:0]    pre_bank_o,
    output logic          xpre_v_o,
    output logic [4:0]    xpre_bank_o,
    output logic          cal_v_o,
    output logic          sam_v_o,
    output logic          stby_v_o,
    output logic          ret_v_o,
    output logic [4:0]    ret_bank_o,
    output logic [5:0]    ret_col_o,
    output logic [127:0]  ret_data_o,
    output logic [15:0]   ret_be_o,
    output logic          wbpre_v_o,
    output logic [4:0]    wbpre_bank_o
);
    logic [PKT_W-1:0] pkt;
    logic             pkt_vld;
    dec_t             dec;

    colpkt_framer #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .attn_i    (attn_i),
        .beat_i    (col_i),
        .pkt_o     (pkt),
        .pkt_vld_o (pkt_vld)
    );

    colpkt_decode u_decode (
        .pkt_i    (pkt),
        .dev_id_i (dev_id_i),
        .dec_o    (dec)
    );

    colpkt_wbuf #(.RTR_CYC(RTR_CYC)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_vld_i  (pkt_vld),
        .dec_i      (dec),
        .wdata_i    (wdata_i),
        .ret_v_o    (ret_v_o),
        .ret_bank_o (ret_bank_o),
        .ret_col_o  (ret_col_o),
        .ret_data_o (ret_data_o),
        .ret_be_o   (ret_be_o),
        .pcw_v_o    (wbpre_v_o),
        .pcw_bank_o (wbpre_bank_o)
    );

    // Register command strobes and their addresses for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_o      <= 1'b0;
            wr_v_o      <= 1'b0;
            pre_v_o     <= 1'b0;
            xpre_v_o    <= 1'b0;
            cal_v_o     <= 1'b0;
            sam_v_o     <= 1'b0;
            stby_v_o    <= 1'b0;
            rd_bank_o   <= '0;
            rd_col_o    <= '0;
            wr_bank_o   <= '0;
            wr_col_o    <= '0;
            pre_bank_o  <= '0;
            xpre_bank_o <= '0;
        end else begin
            rd_v_o   <= pkt_vld && dec.rd;
            wr_v_o   <= pkt_vld && dec.wr;
            pre_v_o  <= pkt_vld && dec.pre;
            xpre_v_o <= pkt_vld && dec.xpre;
            cal_v_o  <= pkt_vld && dec.cal;
            sam_v_o  <= pkt_vld && dec.sam;
            stby_v_o <= pkt_vld && dec.stby;
            if (pkt_vld) begin
                rd_bank_o   <= dec.bank;
                rd_col_o    <= dec.col;
                wr_bank_o   <= dec.bank;
                wr_col_o    <= dec.col;
                pre_bank_o  <= dec.bank;
                xpre_bank_o <= dec.xbank;
            end
        end
    end

    // R3
    rd_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_v_o |-> !ret_v_o);
    // R10
    sam_needs_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sam_v_o |-> cal_v_o);
    // R4
    wr_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_v_o |-> !rd_v_o);
endmodule

// File: tb/colcmd_unit_tb.sv
`timescale 1ns/1ps
module colcmd_unit_tb;
    localparam logic [4:0] DEV = 5'h0B;

    logic clk = 1'b0, rst_n = 1'b0, attn = 1'b1;
    logic [9:0] col = '0;
    logic [127:0] wdata = '0;
    logic rd_v, wr_v, pre_v, xpre_v, cal_v, sam_v, stby_v, ret_v, wbpre_v;
    logic [4:0] rd_bank, wr_bank, pre_bank, xpre_bank, ret_bank, wbpre_bank;
    logic [5:0] rd_col, wr_col, ret_col;
    logic [127:0] ret_data;
    logic [15:0] ret_be;
    int nchk = 0, nerr = 0;

    logic [3:0] op;
    logic [2:0] low;
    logic [4:0] wb, tb, xv;
    logic [5:0] wc, tc;
    logic [127:0] wd;
    logic prev_auto = 1'b0;
    logic [4:0] prev_bank = '0;

    always #4 clk = ~clk;

    colcmd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .attn_i(attn), .dev_id_i(DEV), .col_i(col),
        .wdata_i(wdata), .rd_v_o(rd_v), .rd_bank_o(rd_bank), .rd_col_o(rd_col),
        .wr_v_o(wr_v), .wr_bank_o(wr_bank), .wr_col_o(wr_col),
        .pre_v_o(pre_v), .pre_bank_o(pre_bank), .xpre_v_o(xpre_v),
        .xpre_bank_o(xpre_bank), .cal_v_o(cal_v), .sam_v_o(sam_v),
        .stby_v_o(stby_v), .ret_v_o(ret_v), .ret_bank_o(ret_bank),
        .ret_col_o(ret_col), .ret_data_o(ret_data), .ret_be_o(ret_be),
        .wbpre_v_o(wbpre_v), .wbpre_bank_o(wbpre_bank)
    );

    function automatic logic [39:0] mk(input logic [4:0] d, input logic [4:0] b,
            input logic [5:0] c, input logic [3:0] o, input logic m,
            input logic [15:0] lo);
        return {1'b1, d, b, c, o, 2'b00, m, lo};
    endfunction

    function automatic logic [15:0] xext(input logic [4:0] d, input logic [4:0] b,
            input logic [4:0] x);
        return {d, b, x, 1'b0};
    endfunction

    task automatic chk(input string r, input logic [127:0] a, input logic [127:0] e);
        nchk++;
        if (a !== e) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, a, e);
        end
    endtask

    // Four beats, one idle cycle, then sample after the fifth edge
    task automatic send(input logic [39:0] p, input logic [127:0] d, input logic at);
        wdata = d;
        attn  = at;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            col = p[39-10*k -: 10];
        end
        @(negedge clk);
        col = '0;
        @(negedge clk);
        attn = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 rd", rd_v, 0);
        chk("R12 wr", wr_v, 0);
        chk("R12 ret", ret_v, 0);
        chk("R12 stby", stby_v, 0);
        chk("R12 wbpre", wbpre_v, 0);

        // Opcode sweep, each after a freshly buffered write
        for (int i = 0; i < 16; i++) begin
            op = 4'(i);
            low = op[2:0];
            wb = 5'(i) ^ 5'h03;
            wc = 6'(i * 3);
            wd = {8{8'(i), 8'(8'h40 + i)}};
            send(mk(DEV, wb, wc, 4'b0001, 1'b0, 16'h0), wd, 1'b1);
            chk("R4 wr strobe", wr_v, 1);
            chk("R4 wr bank", wr_bank, wb);
            chk("R9 deferred precharge", wbpre_v, prev_auto);
            if (prev_auto) chk("R9 deferred bank", wbpre_bank, prev_bank);
            tb = 5'h10 | 5'(i);
            tc = 6'h3F - 6'(i);
            send(mk(DEV, tb, tc, op, 1'b0, 16'h0), ~wd, 1'b1);
            chk("R5 retire rule", ret_v, (low == 3'd0 || low == 3'd1 || low == 3'd4 || low == 3'd5));
            chk("R3 read", rd_v, (low == 3'd3 || low == 3'd7));
            chk("R4 write", wr_v, (low == 3'd1 || low == 3'd5));
            chk("R8 precharge", pre_v, (low == 3'd4 || low == 3'd7));
            chk("R11 standby", stby_v, op[3]);
            chk("R9 no early precharge", wbpre_v, 0);
            if (low == 3'd0 || low == 3'd1 || low == 3'd4 || low == 3'd5) begin
                chk("R6 ret data", ret_data, wd);
                chk("R6 ret bank", ret_bank, wb);
                chk("R6 ret col", ret_col, wc);
                chk("R6 full enables", ret_be, 16'hFFFF);
            end
            if (low == 3'd3 || low == 3'd7) begin
                chk("R3 rd bank", rd_bank, tb);
                chk("R3 rd col", rd_col, tc);
            end
            if (low == 3'd4 || low == 3'd7) chk("R8 pre bank", pre_bank, tb);
            prev_auto = (low == 3'd5);
            prev_bank = tb;
        end

        // R5 other device retires; read for it is not ours
        send(mk(DEV ^ 5'h01, 5'h02, 6'h05, 4'b0011, 1'b0, 16'h0), '0, 1'b1);
        chk("R5 other device retire", ret_v, 1);
        chk("R5 other device data", ret_data, wd);
        chk("R5 other device no read", rd_v, 0);
        send(mk(DEV, 5'h00, 6'h00, 4'b0000, 1'b0, 16'h0), '0, 1'b1);
        chk("R5 empty no retire", ret_v, 0);

        // R2 attention gating
        send(mk(DEV, 5'h04, 6'h07, 4'b0001, 1'b0, 16'h0), {16{8'h77}}, 1'b0);
        chk("R2 ignored write", wr_v, 0);
        send(mk(DEV, 5'h00, 6'h00, 4'b0000, 1'b0, 16'h0), '0, 1'b1);
        chk("R2 buffer untouched", ret_v, 0);

        // R7 early mask ignored, later mask accepted
        send(mk(DEV, 5'h07, 6'h09, 4'b0001, 1'b0, 16'h0), {16{8'hC3}}, 1'b1);
        send(mk(DEV, 5'h01, 6'h01, 4'b0011, 1'b1, {8'h3C, 8'hA5}), '0, 1'b1);
        chk("R5 read keeps buffer", ret_v, 0);
        send(mk(DEV, 5'h00, 6'h00, 4'b0000, 1'b1, {8'h0F, 8'hF0}), '0, 1'b1);
        chk("R7 late mask retire", ret_v, 1);
        chk("R7 late mask enables", ret_be, 16'hF00F);
        chk("R6 masked bank", ret_bank, 5'h07);

        // R7 mask stored on a non-retiring packet
        send(mk(DEV, 5'h08, 6'h11, 4'b0001, 1'b0, 16'h0), {16{8'h5A}}, 1'b1);
        send(mk(DEV, 5'h00, 6'h00, 4'b0010, 1'b0, 16'h0), '0, 1'b1);
        chk("R5 reserved keeps buffer", ret_v, 0);
        send(mk(DEV, 5'h02, 6'h02, 4'b0011, 1'b1, {8'h81, 8'h18}), '0, 1'b1);
        chk("R5 read with mask keeps buffer", ret_v, 0);
        send(mk(DEV, 5'h00, 6'h00, 4'b0000, 1'b0, 16'h0), '0, 1'b1);
        chk("R7 stored mask retire", ret_v, 1);
        chk("R7 stored mask enables", ret_be, 16'h1881);
        chk("R6 stored mask data", ret_data, {16{8'h5A}});

        // R10 / R11 extended opcode sweep
        for (int v = 0; v < 32; v++) begin
            xv = 5'(v);
            send(mk(DEV, 5'h00, 6'h00, 4'b0010, 1'b0, xext(DEV, 5'h15, xv)), '0, 1'b1);
            chk("R10 ext precharge", xpre_v, xv[4] & ~xv[0]);
            chk("R10 calibrate", cal_v, xv[3] & ~xv[0]);
            chk("R10 sample", sam_v, xv[3] & xv[2] & ~xv[0]);
            chk("R11 ext standby", stby_v, xv[1] & ~xv[0]);
            if (xv[4] & ~xv[0]) chk("R10 ext bank", xpre_bank, 5'h15);
        end
        send(mk(DEV, 5'h00, 6'h00, 4'b0010, 1'b0, xext(DEV ^ 5'h10, 5'h15, 5'b11110)), '0, 1'b1);
        chk("R10 mismatch precharge", xpre_v, 0);
        chk("R10 mismatch calibrate", cal_v, 0);
        chk("R11 mismatch standby", stby_v, 0);

        // R1 start bit absent: nothing framed
        @(negedge clk); col = 10'h1FF;
        repeat (6) @(negedge clk);
        col = '0;
        chk("R1 no start no strobe", {rd_v, wr_v, ret_v, stby_v, cal_v}, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule